// File: doc/BRIEF.md
# Dual-Unit Floating-Point Issue Scoreboard

This block is the issue and hazard logic in front of a floating-point coprocessor that has two independent pipelined units, an adder and a multiplier. Each cycle it looks at the operation at the head of the decoded stream and decides whether that operation dispatches now or waits. The operation carries a kind code, a destination register tag and two source register tags for each half it uses. The arithmetic itself is not modelled. Each unit is represented only by how long its result takes and how often it can accept work.

The scoreboard keeps a pending bit for every register. The bit is set when an operation that writes the register dispatches, and it is cleared when that result completes. Each unit has a short cooldown counter, because a unit can start work only on every second cycle. A paired kind sends one multiply and one add out together as a single issue. The two halves are unrelated operations and do not form a fused multiply-accumulate. When an operation completes, the block raises a per-unit strobe that carries the destination tag.

Top module: `fp_dual_issue_sb`

## Requirements
- R1: An add dispatched in cycle t raises `add_done` with `add_done_tag` equal to its destination in cycle t+3 and in no other cycle. A multiply behaves the same way on `mul_done`/`mul_done_tag`. Precision does not affect this timing.
- R2: The two units are independent. A multiply may dispatch while an add is in flight or cooling down, and an add may dispatch while a multiply is in flight or cooling down.
- R3: A unit accepts at most one operation in any two consecutive cycles. An operation for a unit that dispatched in the previous cycle stalls for exactly one cycle.
- R4: An operation stalls while any of its sources is pending. A result is usable in its completion cycle, so a reader may dispatch in cycle t+3 of the writer but not in t+1 or t+2.
- R5: An operation whose destination is still pending stalls until that register completes.
- R6: Kind code 2 (pair) dispatches the add half (fields `a_*`) and the multiply half (fields `m_*`) in one cycle as a single issue. It needs both units ready and none of its six tags pending. If either condition fails, the whole pair stalls.
- R7: A pair whose halves are linked never issues and keeps `stall` high. The halves are linked when the destinations are equal or when either half reads the other half's destination.
- R8: Kind code 3 with `in_valid` high is ignored. It raises neither `issue_ok` nor `stall`, and it changes no unit or register state.
- R9: `stall` is high exactly when `in_valid` is high, the kind is not 3, and the operation does not issue. With `in_valid` low, both `issue_ok` and `stall` are low. Kind code 0 is a single add using the `a_*` fields. Kind code 1 is a single multiply using the `m_*` fields.
- R10: A synchronous active-high `rst` clears all pending bits, makes both units ready in the next cycle, and cancels every in-flight result, so no done strobe follows for work dispatched before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Head operation present |
| in_kind | input | 2 | 0 add, 1 multiply, 2 pair, 3 ignored |
| a_dst | input | TAGW | Add half destination tag |
| a_src0 | input | TAGW | Add half first source tag |
| a_src1 | input | TAGW | Add half second source tag |
| m_dst | input | TAGW | Multiply half destination tag |
| m_src0 | input | TAGW | Multiply half first source tag |
| m_src1 | input | TAGW | Multiply half second source tag |
| issue_ok | output | 1 | Head operation dispatches this cycle |
| stall | output | 1 | Head operation held this cycle |
| add_done | output | 1 | Add result completes this cycle |
| add_done_tag | output | TAGW | Destination of the completing add |
| mul_done | output | 1 | Multiply result completes this cycle |
| mul_done_tag | output | TAGW | Destination of the completing multiply |

## Verification
The bench targets the cycle where a reader's source finishes. A design whose pending bits are off by one cycle either lets the reader through in t+2 or holds it until t+4, and the table catches both cases. Back-to-back operations to one unit, and a single operation to the other unit right after, separate a shared occupancy flag from a per-unit one. The bench also drives a pair blocked only by the busy multiplier, a pair whose halves are linked, and an ignored kind, which expose designs that dispatch half a pair, dispatch a pair whose halves depend on each other, or treat kind 3 as work. A reset in the middle of the stream shows whether stale pending bits or stale done strobes survive reset.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
  typedef enum logic [1:0] {
    K_ADD  = 2'd0,
    K_MUL  = 2'd1,
    K_PAIR = 2'd2,
    K_NONE = 2'd3
  } op_kind_e;
endpackage

// File: rtl/fpsb_unit_track.sv
// Occupancy and latency model of one pipelined unit.
module fpsb_unit_track #(
  parameter int TAGW = 5,
  parameter int LAT  = 3,
  parameter int GAP  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [TAGW-1:0] fire_tag,
  output logic            ready,
  output logic            retire_v,
  output logic [TAGW-1:0] retire_tag,
  output logic            done_v,
  output logic [TAGW-1:0] done_tag
);
  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

  logic            vld [1:LAT];
  logic [TAGW-1:0] tg  [1:LAT];
  logic [CW-1:0]   cool;

  for (genvar k = 1; k <= LAT; k++) begin : g_stage
    if (k == 1) begin : g_head
      always_ff @(posedge clk) begin
        vld[k] <= rst ? 1'b0 : fire;
        tg[k]  <= fire_tag;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        vld[k] <= rst ? 1'b0 : vld[k-1];
        tg[k]  <= tg[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             cool <= '0;
    else if (fire)       cool <= CW'(GAP - 1);
    else if (cool != '0) cool <= cool - 1'b1;
  end

  assign ready      = (cool == '0);
  assign retire_v   = vld[LAT-1];
  assign retire_tag = tg[LAT-1];
  assign done_v     = vld[LAT];
  assign done_tag   = tg[LAT];
endmodule

// File: rtl/fpsb_pending_file.sv
// One pending bit per register: set on dispatch, cleared as the result lands.
module fpsb_pending_file #(
  parameter int TAGW = 5,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_a,
  input  logic [TAGW-1:0] set_a_tag,
  input  logic            set_m,
  input  logic [TAGW-1:0] set_m_tag,
  input  logic            clr_a,
  input  logic [TAGW-1:0] clr_a_tag,
  input  logic            clr_m,
  input  logic [TAGW-1:0] clr_m_tag,
  output logic [NREG-1:0] pend
);
  function automatic logic [NREG-1:0] sel(input logic en, input logic [TAGW-1:0] t);
    return en ? (NREG'(1) << t) : '0;
  endfunction

  logic [NREG-1:0] set_mask, clr_mask;
  assign set_mask = sel(set_a, set_a_tag) | sel(set_m, set_m_tag);
  assign clr_mask = sel(clr_a, clr_a_tag) | sel(clr_m, clr_m_tag);

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/fpsb_issue_ctrl.sv
// Combinational dispatch decision for the head operation.
module fpsb_issue_ctrl import fpsb_pkg::*; #(
  parameter int TAGW = 5,
  parameter int NREG = 32
) (
  input  logic            in_valid,
  input  logic [1:0]      in_kind,
  input  logic [TAGW-1:0] a_dst,
  input  logic [TAGW-1:0] a_src0,
  input  logic [TAGW-1:0] a_src1,
  input  logic [TAGW-1:0] m_dst,
  input  logic [TAGW-1:0] m_src0,
  input  logic [TAGW-1:0] m_src1,
  input  logic [NREG-1:0] pend,
  input  logic            add_ready,
  input  logic            mul_ready,
  output logic            issue_ok,
  output logic            stall,
  output logic            fire_add,
  output logic            fire_mul,
  output logic            pair_linked
);
  function automatic logic half_clear(input logic [NREG-1:0] p,
                                      input logic [TAGW-1:0] d,
                                      input logic [TAGW-1:0] s0,
                                      input logic [TAGW-1:0] s1);
    return !(p[d] || p[s0] || p[s1]);
  endfunction

  function automatic logic halves_linked(input logic [TAGW-1:0] ad,
                                         input logic [TAGW-1:0] as0,
                                         input logic [TAGW-1:0] as1,
                                         input logic [TAGW-1:0] md,
                                         input logic [TAGW-1:0] ms0,
                                         input logic [TAGW-1:0] ms1);
    return (ad == md) || (ms0 == ad) || (ms1 == ad) || (as0 == md) || (as1 == md);
  endfunction

  op_kind_e kind;
  logic a_ok, m_ok, go, kind_live;

  assign kind        = op_kind_e'(in_kind);
  assign a_ok        = add_ready && half_clear(pend, a_dst, a_src0, a_src1);
  assign m_ok        = mul_ready && half_clear(pend, m_dst, m_src0, m_src1);
  assign pair_linked = halves_linked(a_dst, a_src0, a_src1, m_dst, m_src0, m_src1);

  always_comb begin
    go        = 1'b0;
    kind_live = 1'b1;
    fire_add  = 1'b0;
    fire_mul  = 1'b0;
    unique case (kind)
      K_ADD:  begin go = a_ok; fire_add = in_valid && a_ok; end
      K_MUL:  begin go = m_ok; fire_mul = in_valid && m_ok; end
      K_PAIR: begin
        go       = a_ok && m_ok && !pair_linked;
        fire_add = in_valid && go;
        fire_mul = in_valid && go;
      end
      K_NONE: kind_live = 1'b0;
    endcase
  end

  assign issue_ok = in_valid && go;
  assign stall    = in_valid && kind_live && !go;
endmodule

// File: rtl/fp_dual_issue_sb.sv
module fp_dual_issue_sb import fpsb_pkg::*; #(
  parameter int TAGW = 5,
  parameter int LAT  = 3,
  parameter int GAP  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_kind,
  input  logic [TAGW-1:0] a_dst,
  input  logic [TAGW-1:0] a_src0,
  input  logic [TAGW-1:0] a_src1,
  input  logic [TAGW-1:0] m_dst,
  input  logic [TAGW-1:0] m_src0,
  input  logic [TAGW-1:0] m_src1,
  output logic            issue_ok,
  output logic            stall,
  output logic            add_done,
  output logic [TAGW-1:0] add_done_tag,
  output logic            mul_done,
  output logic [TAGW-1:0] mul_done_tag
);
  localparam int NREG = 1 << TAGW;

  logic [NREG-1:0] pend;
  logic            add_ready, mul_ready;
  logic            fire_add, fire_mul, pair_linked;
  logic            add_ret_v, mul_ret_v;
  logic [TAGW-1:0] add_ret_tag, mul_ret_tag;

  fpsb_issue_ctrl #(.TAGW(TAGW), .NREG(NREG)) u_ctrl (
    .in_valid, .in_kind, .a_dst, .a_src0, .a_src1, .m_dst, .m_src0, .m_src1,
    .pend, .add_ready, .mul_ready,
    .issue_ok, .stall, .fire_add, .fire_mul, .pair_linked
  );

  fpsb_unit_track #(.TAGW(TAGW), .LAT(LAT), .GAP(GAP)) u_add (
    .clk, .rst, .fire(fire_add), .fire_tag(a_dst), .ready(add_ready),
    .retire_v(add_ret_v), .retire_tag(add_ret_tag),
    .done_v(add_done), .done_tag(add_done_tag)
  );

  fpsb_unit_track #(.TAGW(TAGW), .LAT(LAT), .GAP(GAP)) u_mul (
    .clk, .rst, .fire(fire_mul), .fire_tag(m_dst), .ready(mul_ready),
    .retire_v(mul_ret_v), .retire_tag(mul_ret_tag),
    .done_v(mul_done), .done_tag(mul_done_tag)
  );

  fpsb_pending_file #(.TAGW(TAGW), .NREG(NREG)) u_pend (
    .clk, .rst,
    .set_a(fire_add), .set_a_tag(a_dst),
    .set_m(fire_mul), .set_m_tag(m_dst),
    .clr_a(add_ret_v), .clr_a_tag(add_ret_tag),
    .clr_m(mul_ret_v), .clr_m_tag(mul_ret_tag),
    .pend
  );
endmodule

// File: rtl/fpsb_sva.sv
module fpsb_sva #(
  parameter int TAGW = 5,
  parameter int NREG = 32,
  parameter int LAT  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      in_kind,
  input logic [TAGW-1:0] a_dst,
  input logic [TAGW-1:0] a_src0,
  input logic [TAGW-1:0] a_src1,
  input logic [TAGW-1:0] m_dst,
  input logic            issue_ok,
  input logic            stall,
  input logic            fire_add,
  input logic            fire_mul,
  input logic            pair_linked,
  input logic [NREG-1:0] pend,
  input logic            add_done,
  input logic [TAGW-1:0] add_done_tag,
  input logic            mul_done,
  input logic [TAGW-1:0] mul_done_tag
);
  p_issue_stall_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(issue_ok && stall));

  p_add_latency_r1: assert property (@(posedge clk) disable iff (rst)
    add_done |-> ($past(fire_add, LAT) && add_done_tag == $past(a_dst, LAT)));

  p_mul_latency_r1: assert property (@(posedge clk) disable iff (rst)
    mul_done |-> ($past(fire_mul, LAT) && mul_done_tag == $past(m_dst, LAT)));

  p_add_gap_r3: assert property (@(posedge clk) disable iff (rst)
    fire_add |=> !fire_add);

  p_mul_gap_r3: assert property (@(posedge clk) disable iff (rst)
    fire_mul |=> !fire_mul);

  p_raw_fresh_r4: assert property (@(posedge clk) disable iff (rst)
    (fire_add && !$past(rst)) |->
      !($past(fire_add) && ($past(a_dst) == a_src0 || $past(a_dst) == a_src1)));

  p_pair_both_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && in_kind == 2'd2) |-> (fire_add && fire_mul));

  p_issue_has_unit_r9: assert property (@(posedge clk) disable iff (rst)
    issue_ok |-> (fire_add || fire_mul));

  p_linked_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (pair_linked && in_kind == 2'd2) |-> !issue_ok);

  p_none_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (in_kind == 2'd3) |-> (!fire_add && !fire_mul && !stall));

  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (pend == '0 && !add_done && !mul_done));
endmodule

bind fp_dual_issue_sb fpsb_sva #(.TAGW(TAGW), .NREG(NREG), .LAT(LAT)) u_sva (
  .clk, .rst, .in_kind, .a_dst, .a_src0, .a_src1, .m_dst,
  .issue_ok, .stall, .fire_add, .fire_mul, .pair_linked, .pend,
  .add_done, .add_done_tag, .mul_done, .mul_done_tag
);

// File: tb/fp_dual_issue_sb_tb.sv
module fp_dual_issue_sb_tb;
  localparam int TAGW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic [TAGW-1:0] a_dst = '0, a_src0 = '0, a_src1 = '0;
  logic [TAGW-1:0] m_dst = '0, m_src0 = '0, m_src1 = '0;
  logic issue_ok, stall, add_done, mul_done;
  logic [TAGW-1:0] add_done_tag, mul_done_tag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fp_dual_issue_sb #(.TAGW(TAGW)) u_dut (
    .clk, .rst, .in_valid, .in_kind, .a_dst, .a_src0, .a_src1,
    .m_dst, .m_src0, .m_src1, .issue_ok, .stall,
    .add_done, .add_done_tag, .mul_done, .mul_done_tag
  );

  typedef struct packed {
    logic       v;
    logic [1:0] k;
    logic [4:0] ad, as0, as1, md, ms0, ms1;
    logic       ei, es, ea;
    logic [4:0] eat;
    logic       em;
    logic [4:0] emt;
    logic [3:0] req;
  } vec_t;

  // kind: 0 add, 1 mul, 2 pair, 3 ignored; one entry per cycle
  localparam vec_t VECS [18] = '{
    '{1'b1, 2'd0,  5'd1,  5'd2,  5'd3,  5'd0,  5'd0,  5'd0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  4'd1}, // R1 add to r1
    '{1'b1, 2'd0,  5'd4,  5'd5,  5'd6,  5'd0,  5'd0,  5'd0, 1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  4'd3}, // R3 adder cooling
    '{1'b1, 2'd0,  5'd4,  5'd5,  5'd6,  5'd0,  5'd0,  5'd0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  4'd3}, // R3 one-cycle wait
    '{1'b1, 2'd1,  5'd0,  5'd0,  5'd0,  5'd7,  5'd1,  5'd2, 1'b1, 1'b0, 1'b1, 5'd1,  1'b0, 5'd0,  4'd4}, // R4 read r1 in its done cycle
    '{1'b1, 2'd0,  5'd9,  5'd4,  5'd0,  5'd0,  5'd0,  5'd0, 1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  4'd4}, // R4 r4 still pending
    '{1'b1, 2'd0,  5'd9,  5'd4,  5'd0,  5'd0,  5'd0,  5'd0, 1'b1, 1'b0, 1'b1, 5'd4,  1'b0, 5'd0,  4'd4}, // R4 r4 lands
    '{1'b1, 2'd1,  5'd0,  5'd0,  5'd0,  5'd10, 5'd11, 5'd12, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 5'd7,  4'd1}, // R1 mul done r7
    '{1'b1, 2'd2,  5'd13, 5'd14, 5'd15, 5'd16, 5'd17, 5'd18, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0,  4'd6}, // R6 mul busy, whole pair waits
    '{1'b1, 2'd2,  5'd13, 5'd14, 5'd15, 5'd16, 5'd17, 5'd18, 1'b1, 1'b0, 1'b1, 5'd9, 1'b0, 5'd0,  4'd6}, // R6 pair goes
    '{1'b1, 2'd3,  5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  5'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 5'd10, 4'd8}, // R8 ignored kind
    '{1'b1, 2'd2,  5'd20, 5'd21, 5'd22, 5'd23, 5'd20, 5'd24, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0,  4'd7}, // R7 linked halves
    '{1'b0, 2'd0,  5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  5'd0, 1'b0, 1'b0, 1'b1, 5'd13, 1'b1, 5'd16, 4'd9}, // R9 idle, pair lands
    '{1'b1, 2'd0,  5'd25, 5'd26, 5'd27, 5'd0,  5'd0,  5'd0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  4'd2}, // R2 add
    '{1'b1, 2'd1,  5'd0,  5'd0,  5'd0,  5'd26, 5'd28, 5'd29, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0,  4'd2}, // R2 mul beside busy adder
    '{1'b1, 2'd0,  5'd25, 5'd0,  5'd0,  5'd0,  5'd0,  5'd0, 1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  4'd5}, // R5 dest r25 pending
    '{1'b0, 2'd0,  5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  5'd0, 1'b0, 1'b0, 1'b1, 5'd25, 1'b0, 5'd0,  4'd1}, // R1
    '{1'b0, 2'd0,  5'd0,  5'd0,  5'd0,  5'd0,  5'd0,  5'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 5'd26, 4'd1}, // R1
    '{1'b1, 2'd1,  5'd0,  5'd0,  5'd0,  5'd1,  5'd2,  5'd3, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  4'd2}  // R2
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k,
                       input logic [4:0] ad, input logic [4:0] as0, input logic [4:0] as1,
                       input logic [4:0] md, input logic [4:0] ms0, input logic [4:0] ms1);
    in_valid = v; in_kind = k;
    a_dst = ad; a_src0 = as0; a_src1 = as1;
    m_dst = md; m_src0 = ms0; m_src1 = ms1;
  endtask

  task automatic chk_done(input string req, input logic ea, input logic [4:0] eat,
                          input logic em, input logic [4:0] emt);
    chk(req, "add_done", int'(add_done), int'(ea));
    if (ea) chk(req, "add_done_tag", int'(add_done_tag), int'(eat));
    chk(req, "mul_done", int'(mul_done), int'(em));
    if (em) chk(req, "mul_done_tag", int'(mul_done_tag), int'(emt));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R10 reset state while still in reset
    chk("R10", "done strobes in reset", int'(add_done || mul_done), 0);
    chk("R9", "issue_ok idle", int'(issue_ok), 0);
    chk("R9", "stall idle", int'(stall), 0);
    rst = 1'b0;

    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      drive(VECS[i].v, VECS[i].k, VECS[i].ad, VECS[i].as0, VECS[i].as1,
            VECS[i].md, VECS[i].ms0, VECS[i].ms1);
      #1;
      chk($sformatf("R%0d", VECS[i].req), $sformatf("issue_ok v%0d", i),
          int'(issue_ok), int'(VECS[i].ei));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("stall v%0d", i),
          int'(stall), int'(VECS[i].es));
      chk_done($sformatf("R%0d", VECS[i].req), VECS[i].ea, VECS[i].eat, VECS[i].em, VECS[i].emt);
    end

    // Mid-stream reset: in-flight add to r5 is cancelled and r5 unlocks (R10)
    @(negedge clk);
    drive(1'b1, 2'd0, 5'd5, 5'd6, 5'd7, 5'd0, 5'd0, 5'd0);
    #1;
    chk("R10", "pre-reset add issues", int'(issue_ok), 1);
    @(negedge clk);
    rst = 1'b1;
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 2'd0, 5'd8, 5'd5, 5'd0, 5'd0, 5'd0, 5'd0);
    #1;
    chk("R10", "reader of r5 after reset", int'(issue_ok), 1);
    chk_done("R10", 1'b0, 5'd0, 1'b0, 5'd0);
    @(negedge clk);
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    #1;
    chk_done("R10", 1'b0, 5'd0, 1'b0, 5'd0);
    @(negedge clk);
    #1;
    chk_done("R10", 1'b0, 5'd0, 1'b0, 5'd0);
    @(negedge clk);
    #1;
    chk_done("R1", 1'b1, 5'd8, 1'b0, 5'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule